// File: doc/BRIEF.md
# Fully Associative Tag Match Store

This block holds the tags of a small fully associative cache. An address presented on the lookup port has no index field. It is split into a block tag and a byte offset, and the tag is compared against every stored entry in the same cycle. The block returns a hit flag, the number of the matching entry and the offset. A flag also reports when more than one entry holds the same tag.

A fill port writes a new tag into the entry the block nominates as victim and marks that entry valid. The victim is the lowest-numbered entry that is not valid. When every entry is valid, the victim comes from a round-robin pointer that steps forward on each fill into the full store. A flush input invalidates the whole store in one clock. The data array, the memory side and any recency tracking are outside this block.

Top module: `tag_cam_fa`

## Requirements
- R1: The lookup address splits into an offset, bits [4:0], which is returned unchanged on `lk_offset`, and a 27-bit tag, bits [31:5]. No bits serve as an index.
- R2: `lk_hit` is high in the same cycle as the lookup address if and only if at least one valid entry holds a tag equal to the lookup tag.
- R3: `lk_entry` is the lowest-numbered matching entry. It is 0 when there is no hit.
- R4: `lk_multi` is high exactly when two or more valid entries match the lookup tag. `lk_entry` still reports the lowest of them.
- R5: While any entry is invalid, `vic_entry` is the lowest-numbered invalid entry and `vic_full` is low.
- R6: While all entries are valid, `vic_full` is high and `vic_entry` is the round-robin pointer. The pointer is 0 after reset. It advances by one, wrapping from ENTRIES-1 to 0, after each fill accepted while the store is full. A flush leaves the pointer unchanged.
- R7: A fill (`fill_en` high, `flush` low) writes `fill_tag` into entry `vic_entry` and marks it valid. The change is visible to lookups from the next clock edge.
- R8: `flush` clears every valid bit at the next clock edge. It takes priority over a fill in the same cycle, and that fill has no effect.
- R9: After reset no entry is valid. Lookups miss, `vic_entry` is 0 and `vic_full` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lk_addr | input | 32 | Lookup byte address |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_entry | output | IDX_W (3) | Lowest matching entry number |
| lk_offset | output | 5 | Byte offset within the block |
| lk_multi | output | 1 | More than one entry matched |
| fill_en | input | 1 | Write `fill_tag` into the victim entry |
| fill_tag | input | 27 | Tag to store |
| flush | input | 1 | Invalidate all entries |
| vic_entry | output | IDX_W (3) | Entry the next fill will use |
| vic_full | output | 1 | Every entry is valid |

## Verification
The bench fills the store up to and past capacity. A design that skipped the free-slot preference, or started its pointer at the wrong entry, would overwrite a live tag and report the wrong victim. It also writes one tag twice, so the duplicate case shows whether the priority encoder picks the lowest entry and raises the multi flag, rather than merging indexes or reporting the highest one. A flush issued together with a fill exposes a design that lets the write slip through. Further lookups differ from a stored tag in a single tag bit, or match it only in the offset. A comparator that ignores the valid bit or compares the offset bits would then return a false hit.

// File: rtl/tcam_pkg.sv
`timescale 1ns/1ps
package tcam_pkg;
  localparam int unsigned TCAM_ADDR_W = 32;
  localparam int unsigned TCAM_OFFS_W = 5;
  localparam int unsigned TCAM_TAG_W  = TCAM_ADDR_W - TCAM_OFFS_W;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tcam_match.sv
`timescale 1ns/1ps
module tcam_match #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned TAG_W   = 27
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]              key,
  output logic [ENTRIES-1:0]            match
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/tcam_prienc.sv
`timescale 1ns/1ps
module tcam_prienc #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output logic               multi
);
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any   = |req;
  assign multi = ($countones(req) > 1);
endmodule

// File: rtl/tcam_victim.sv
`timescale 1ns/1ps
module tcam_victim #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid,
  input  logic               adv,
  output logic [IDX_W-1:0]   vic,
  output logic               full
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] free_idx;
  logic             rr_en;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign full  = &valid;
  assign vic   = full ? rr_q : free_idx;
  assign rr_en = adv && full;

  always_comb begin
    rr_d = rr_q;
    if (rr_en) rr_d = (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= '0;
    else if (rr_en) rr_q <= rr_d;
  end

  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && full) |=> (rr_q == (($past(rr_q) == LAST) ? '0 : $past(rr_q) + 1'b1))); // R6
  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && full) |=> $stable(rr_q)); // R6
  AST_VIC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !valid[vic]); // R5
endmodule

// File: rtl/tag_cam_fa.sv
`timescale 1ns/1ps
module tag_cam_fa
  import tcam_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ADDR_W  = TCAM_ADDR_W,
  parameter int unsigned OFFS_W  = TCAM_OFFS_W,
  parameter int unsigned IDX_W   = idx_width(ENTRIES),
  parameter int unsigned TAG_W   = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_entry,
  output logic [OFFS_W-1:0] lk_offset,
  output logic              lk_multi,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              flush,
  output logic [IDX_W-1:0]  vic_entry,
  output logic              vic_full
);
  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [ENTRIES-1:0]            match;
  logic [TAG_W-1:0]              lk_tag;
  logic                          wr_en;

  assign lk_tag    = lk_addr[ADDR_W-1:OFFS_W];
  assign lk_offset = lk_addr[OFFS_W-1:0];
  assign wr_en     = fill_en && !flush;

  tcam_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
    .valid (valid_q),
    .tags  (tag_q),
    .key   (lk_tag),
    .match (match)
  );

  tcam_prienc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_enc (
    .req   (match),
    .any   (lk_hit),
    .idx   (lk_entry),
    .multi (lk_multi)
  );

  tcam_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_vic (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (valid_q),
    .adv   (wr_en),
    .vic   (vic_entry),
    .full  (vic_full)
  );

  always_comb begin
    valid_d = valid_q;
    if (flush)      valid_d = '0;
    else if (wr_en) valid_d[vic_entry] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // Tag storage carries no reset; entries are qualified by valid_q.
  always_ff @(posedge clk) begin
    if (wr_en) tag_q[vic_entry] <= fill_tag;
  end

  AST_HIT_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (valid_q[lk_entry] && tag_q[lk_entry] == lk_tag)); // R2
  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit); // R4
  AST_MISS_ENTRY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_entry == '0)); // R3
  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(vic_entry)]); // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0)); // R8
endmodule

// File: tb/tag_cam_fa_bench.sv
`timescale 1ns/1ps
module tag_cam_fa_bench;
  localparam int N  = 8;
  localparam int IW = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_addr;
  logic        lk_hit, lk_multi, vic_full;
  logic [IW-1:0] lk_entry, vic_entry;
  logic [4:0]  lk_offset;
  logic        fill_en, flush;
  logic [26:0] fill_tag;

  always #2.5 clk = ~clk;

  tag_cam_fa u_tag_cam_fa (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_entry(lk_entry), .lk_offset(lk_offset), .lk_multi(lk_multi),
    .fill_en(fill_en), .fill_tag(fill_tag), .flush(flush),
    .vic_entry(vic_entry), .vic_full(vic_full)
  );

  typedef struct {
    logic [13:0] v;
    string       req;
  } exp_t;

  exp_t  q[$];
  event  smp_ev;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;

  bit          mv[N];
  logic [26:0] mt[N];
  int          rr = 0;

  function automatic bit m_full();
    for (int i = 0; i < N; i++) if (!mv[i]) return 0;
    return 1;
  endfunction

  function automatic int m_vic();
    for (int i = 0; i < N; i++) if (!mv[i]) return i;
    return rr;
  endfunction

  // Driver: applies a lookup and pushes the expected outputs.
  task automatic look(input logic [31:0] a, input string req);
    exp_t e;
    int   cnt = 0;
    logic [IW-1:0] ent = '0;
    for (int i = N - 1; i >= 0; i--)
      if (mv[i] && mt[i] == a[31:5]) begin cnt++; ent = IW'(i); end
    e.v   = {cnt > 0, ent, a[4:0], cnt > 1, IW'(m_vic()), m_full()};
    e.req = req;
    @(negedge clk);
    lk_addr = a;
    q.push_back(e);
    #1 -> smp_ev;
  endtask

  task automatic fill(input logic [26:0] t, input bit fl);
    int  v  = m_vic();
    bit  wf = m_full();
    @(negedge clk);
    fill_en = 1'b1; fill_tag = t; flush = fl;
    @(posedge clk);
    #1;
    fill_en = 1'b0; flush = 1'b0;
    if (fl) begin
      for (int i = 0; i < N; i++) mv[i] = 0;
    end else begin
      mv[v] = 1; mt[v] = t;
      if (wf) rr = (rr + 1) % N;
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    #1 flush = 1'b0;
    for (int i = 0; i < N; i++) mv[i] = 0;
  endtask

  // Monitor: pops expectations and compares against the ports.
  always @(smp_ev) begin
    exp_t        e;
    logic [13:0] act;
    e   = q.pop_front();
    act = {lk_hit, lk_entry, lk_offset, lk_multi, vic_entry, vic_full};
    n_cmp++;
    if (act !== e.v) begin
      n_bad++;
      $display("FAIL %s: got hit=%b ent=%0d off=%h multi=%b vic=%0d full=%b, want hit=%b ent=%0d off=%h multi=%b vic=%0d full=%b",
        e.req, act[13], act[12:10], act[9:5], act[4], act[3:1], act[0],
        e.v[13], e.v[12:10], e.v[9:5], e.v[4], e.v[3:1], e.v[0]);
    end
  end

  function automatic logic [31:0] mk(input logic [26:0] t, input logic [4:0] o);
    return {t, o};
  endfunction

  initial begin
    rst_n = 1'b0; lk_addr = '0; fill_en = 1'b0; fill_tag = '0; flush = 1'b0;
    for (int i = 0; i < N; i++) begin mv[i] = 0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    look(32'h0000_0000, "R9 reset miss, victim 0");
    look(32'hDEAD_BEEF, "R9 reset miss any address");

    fill(27'h0080_0001, 0);
    look(mk(27'h0080_0001, 5'h17), "R1 R2 R7 hit entry 0, offset passthrough");
    look(mk(27'h0080_0001, 5'h00), "R1 offset zero");
    look(mk(27'h0080_0003, 5'h17), "R2 one tag bit differs -> miss");
    look(mk(27'h0080_0000, 5'h01), "R2 offset-only match -> miss");

    for (int k = 1; k < N; k++) begin
      fill(27'h0100_0000 + 27'(k * 5), 0);
      look(mk(27'h0100_0000 + 27'(k * 5), 5'(k)), "R5 R3 free-first allocation");
    end
    look(mk(27'h0080_0001, 5'h1F), "R6 full store, pointer at 0");

    fill(27'h02AA_AAAA, 0);
    look(mk(27'h0080_0001, 5'h04), "R6 replaced tag now misses");
    look(mk(27'h02AA_AAAA, 5'h04), "R6 R7 new tag in entry 0, pointer 1");
    fill(27'h0155_5555, 0);
    look(mk(27'h0155_5555, 5'h08), "R6 second replacement at entry 1");
    look(mk(27'h0100_0000 + 27'd5, 5'h08), "R6 evicted entry 1 misses");
    for (int k = 0; k < N - 1; k++) fill(27'h0300_0000 + 27'(k), 0);
    look(mk(27'h0300_0000 + 27'(N - 2), 5'h02), "R6 pointer wrap to entry 0");
    look(mk(27'h0300_0000 + 27'(N - 3), 5'h02), "R3 hit at last entry");

    do_flush();
    look(mk(27'h02AA_AAAA, 5'h00), "R8 flush clears all");
    look(mk(27'h0300_0000, 5'h00), "R8 flush, victim back to 0");

    fill(27'h0444_4444, 1);
    look(mk(27'h0444_4444, 5'h03), "R8 flush beats fill");

    fill(27'h0123_4567, 0);
    fill(27'h0123_4567, 0);
    look(mk(27'h0123_4567, 5'h11), "R4 duplicate tag: multi, lowest entry");
    fill(27'h0765_4321, 0);
    look(mk(27'h0765_4321, 5'h11), "R3 single hit at entry 2, victim 3");

    rst_n = 1'b0;
    #3 rst_n = 1'b1;
    for (int i = 0; i < N; i++) mv[i] = 0;
    rr = 0;
    look(mk(27'h0765_4321, 5'h00), "R9 reset clears valid bits");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule